// File: doc/BRIEF.md
# Three-Level Carrier-Disposition Sine-Triangle Modulator

This block drives one phase leg of a three-level neutral-point-clamped inverter. A phase accumulator walks a sine table to produce a sampled reference. The reference is scaled by a programmable modulation index and compared against two triangular carriers. The upper carrier spans the band from zero up to positive full scale and the lower carrier spans the band from negative full scale up to just below zero. Each comparison decides one half of the leg, and the pair of results selects one of three output levels. That level is then turned into the four gate drives of the leg.

The carrier phase is kept locked to the reference. Every clock it advances by the reference frequency word multiplied by the carrier-to-reference ratio, so the carrier frequency is exactly `ratio` times the reference frequency. An odd ratio gives a half-wave symmetric output. The two carriers can run in phase, or the lower one can be mirrored so that it runs in opposition to the upper one. A new modulation index or disposition is only taken up when a carrier period starts. Modulation indices above one are allowed. In that case the reference leaves the carrier band and the leg stays at its extreme level for whole carrier periods.

Top module: `spwm3l_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `level` is 2'b00 and the gates show the zero pattern (`gate_s2` = `gate_s1n` = 1, `gate_s1` = `gate_s2n` = 0). Reset clears both phases to zero and loads an active modulation index of zero.
- R2: `level` takes only the values 2'b01 (positive), 2'b00 (zero) and 2'b11 (negative). The gates, written as (s1, s2, s1n, s2n), are 1100 for positive, 0110 for zero and 0011 for negative.
- R3: `gate_s1n` is always the inverse of `gate_s1`, and `gate_s2n` is always the inverse of `gate_s2`.
- R4: With a modulation index of zero, `level` stays at zero on every cycle. This follows from the strict comparison: the upper carrier covers 0 to 2^15-1 and the lower carrier covers -2^15 to -1.
- R5: The carrier phase advances by `freq_word`×`ratio`/2^16 of a period per clock, so one reference period holds `ratio` carrier periods. With an index of at most one, one reference period therefore contains between `ratio`/2-1 and `ratio`/2+2 positive pulses.
- R6: With an odd `ratio`, the number of positive-level cycles over one reference period matches the number of negative-level cycles to within 1/16 plus 8.
- R7: The carrier starts at the bottom of its band at reset. In in-phase mode (`disp_mode`=0) negative pulses fall in the middle of a carrier period, and in opposed mode (`disp_mode`=1) they fall around the period boundary. The mode can be switched without a reset, and the output lags the carrier phase by three clocks.
- R8: With an index of at most one, no run of positive level lasts a whole carrier period. With index 3.0 (`mod_index`=768, with 8 fractional bits) both the positive and the negative runs last longer than a carrier period.
- R9: A change of `mod_index` or `disp_mode` only takes effect at the next carrier period boundary. Until then the output follows the settings that were active before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 16 | Reference phase increment per clock |
| ratio | input | 8 | Carrier-to-reference frequency ratio |
| mod_index | input | 10 | Modulation index, unsigned, 8 fractional bits |
| disp_mode | input | 1 | 0 = carriers in phase, 1 = lower carrier in opposition |
| gate_s1 | output | 1 | Outer upper switch |
| gate_s2 | output | 1 | Inner upper switch |
| gate_s1n | output | 1 | Inner lower switch, inverse of gate_s1 |
| gate_s2n | output | 1 | Outer lower switch, inverse of gate_s2 |
| level | output | 2 | Output level code: 01 positive, 00 zero, 11 negative |

## Verification
The bench tracks where the negative pulses sit inside the carrier period in each disposition. If the lower carrier were built the same way in both modes, the opposed mode would show mid-period pulses and would be caught. A modulation index applied in the middle of a carrier period must leave the output at zero until the next boundary. A design that took the index up at once would emit positive pulses several hundred cycles too early. Overmodulation must hold the extreme levels across whole carrier periods, and a design that saturated or wrapped the scaled reference would break those runs. The bench also counts the positive and negative cycles against each other and counts the pulses per reference period, which shows up a wrongly mirrored lower band or a carrier frequency that is not locked to the ratio.

// File: rtl/spwm3l_pkg.sv
package spwm3l_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_e;

  typedef enum logic {
    DISP_INPHASE = 1'b0,
    DISP_OPPOSED = 1'b1
  } disp_e;

  typedef struct packed {
    logic s1;
    logic s2;
    logic s1n;
    logic s2n;
  } gates_t;

  function automatic gates_t level_to_gates(level_e lv);
    gates_t g;
    case (lv)
      LVL_POS: g = '{s1: 1'b1, s2: 1'b1, s1n: 1'b0, s2n: 1'b0};
      LVL_NEG: g = '{s1: 1'b0, s2: 1'b0, s1n: 1'b1, s2n: 1'b1};
      default: g = '{s1: 1'b0, s2: 1'b1, s1n: 1'b1, s2n: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/spwm3l_phase.sv
module spwm3l_phase
  import spwm3l_pkg::*;
#(
  parameter int PW      = 16,
  parameter int DW      = 16,
  parameter int LUT_AW  = 8,
  parameter int RATIO_W = 8,
  parameter int MI_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      freq_word,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [MI_W-1:0]    mi_in,
  input  disp_e              mode_in,
  output logic [LUT_AW-1:0]  rom_addr,
  output logic [DW-2:0]      tri_a,
  output logic [MI_W-1:0]    mi_act,
  output disp_e              mode_act
);

  logic [PW-1:0] ref_ph;
  logic [PW-1:0] car_ph;
  logic [PW-1:0] step;
  logic [PW:0]   car_sum;
  logic          wrap;

  // carrier phase is ratio times the reference phase, kept exact by a shared step
  assign step     = freq_word * {{(PW-RATIO_W){1'b0}}, ratio};
  assign car_sum  = {1'b0, car_ph} + {1'b0, step};
  assign wrap     = car_sum[PW];
  assign rom_addr = ref_ph[PW-1 -: LUT_AW];
  // fold the carrier phase into an up/down triangle starting at band bottom
  assign tri_a    = car_ph[PW-1] ? ~car_ph[PW-2 -: DW-1] : car_ph[PW-2 -: DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ph   <= '0;
      car_ph   <= '0;
      mi_act   <= '0;
      mode_act <= DISP_INPHASE;
    end else begin
      ref_ph <= ref_ph + freq_word;
      car_ph <= car_sum[PW-1:0];
      if (wrap) begin
        mi_act   <= mi_in;
        mode_act <= mode_in;
      end
    end
  end

  AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wrap) |=> ($stable(mi_act) && $stable(mode_act))); // R9

endmodule

// File: rtl/spwm3l_sine_rom.sv
module spwm3l_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] data
);

  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] mem [0:DEPTH-1];

  // half-sample offset makes entry i+DEPTH/2 the exact negative of entry i
  function automatic logic signed [DW-1:0] sine_at(int idx);
    real ang;
    real amp;
    ang = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / real'(DEPTH);
    amp = real'((1 << (DW-1)) - 1);
    return DW'($rtoi(amp * $sin(ang)));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = sine_at(i);
  end

  always_ff @(posedge clk) data <= mem[addr];

endmodule

// File: rtl/spwm3l_refpath.sv
module spwm3l_refpath
  import spwm3l_pkg::*;
#(
  parameter int DW      = 16,
  parameter int LUT_AW  = 8,
  parameter int MI_W    = 10,
  parameter int MI_FRAC = 8,
  parameter int RW      = DW + MI_W + 1 - MI_FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LUT_AW-1:0]    rom_addr,
  input  logic [DW-2:0]        tri_a,
  input  logic [MI_W-1:0]      mi_act,
  input  disp_e                mode_act,
  output logic signed [RW-1:0] ref_c,
  output logic [DW-2:0]        tri_c,
  output disp_e                mode_c
);

  localparam int PRW = DW + MI_W + 1;

  logic signed [DW-1:0]  lut_q;
  logic [DW-2:0]         tri_b;
  logic [MI_W-1:0]       mi_b;
  disp_e                 mode_b;
  logic signed [PRW-1:0] prod;

  spwm3l_sine_rom #(.AW(LUT_AW), .DW(DW)) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .data (lut_q)
  );

  assign prod = lut_q * $signed({1'b0, mi_b});

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_b  <= '0;
      mi_b   <= '0;
      mode_b <= DISP_INPHASE;
      ref_c  <= '0;
      tri_c  <= '0;
      mode_c <= DISP_INPHASE;
    end else begin
      tri_b  <= tri_a;
      mi_b   <= mi_act;
      mode_b <= mode_act;
      ref_c  <= RW'(prod >>> MI_FRAC);
      tri_c  <= tri_b;
      mode_c <= mode_b;
    end
  end

  AST_ZERO_INDEX_REF: assert property (@(posedge clk) disable iff (rst)
    (!rst && mi_b == '0) |=> (ref_c == '0)); // R4

endmodule

// File: rtl/spwm3l_compare.sv
module spwm3l_compare
  import spwm3l_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [RW-1:0] ref_c,
  input  logic [DW-2:0]        tri_c,
  input  disp_e                mode_c,
  output level_e               level_q,
  output gates_t               gates_q
);

  localparam int HALF = 1 << (DW-1);
  localparam int FS   = HALF - 1;

  logic signed [RW-1:0] car_up;
  logic signed [RW-1:0] car_lo;
  logic                 above_up;
  logic                 above_lo;
  level_e               level_d;

  assign car_up = $signed({{(RW-DW+1){1'b0}}, tri_c});

  // opposed carrier is the mirror of the upper band: -1 - up equals ~up
  generate
    if (DW > 1) begin : g_lower
      always_comb begin
        if (mode_c == DISP_OPPOSED) car_lo = ~car_up;
        else                        car_lo = car_up - RW'(HALF);
      end
    end
  endgenerate

  assign above_up = ref_c > car_up;
  assign above_lo = ref_c > car_lo;

  always_comb begin
    if (above_up)      level_d = LVL_POS;
    else if (above_lo) level_d = LVL_ZERO;
    else               level_d = LVL_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_ZERO;
      gates_q <= level_to_gates(LVL_ZERO);
    end else begin
      level_q <= level_d;
      gates_q <= level_to_gates(level_d);
    end
  end

  AST_ZERO_REF_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!rst && ref_c == '0) |=> (level_q == LVL_ZERO)); // R4
  AST_OVERMOD_POS: assert property (@(posedge clk) disable iff (rst)
    (!rst && ref_c > RW'(FS)) |=> (level_q == LVL_POS)); // R8
  AST_OVERMOD_NEG: assert property (@(posedge clk) disable iff (rst)
    (!rst && ref_c < -RW'(HALF)) |=> (level_q == LVL_NEG)); // R8
  AST_GATE_COMPL: assert property (@(posedge clk) disable iff (rst)
    (gates_q.s1 != gates_q.s1n) && (gates_q.s2 != gates_q.s2n)); // R3
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_ZERO) |-> (gates_q.s2 && gates_q.s1n && !gates_q.s1 && !gates_q.s2n)); // R2

endmodule

// File: rtl/spwm3l_gen.sv
module spwm3l_gen
  import spwm3l_pkg::*;
#(
  parameter int PW      = 16,
  parameter int DW      = 16,
  parameter int LUT_AW  = 8,
  parameter int RATIO_W = 8,
  parameter int MI_W    = 10,
  parameter int MI_FRAC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      freq_word,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [MI_W-1:0]    mod_index,
  input  logic               disp_mode,
  output logic               gate_s1,
  output logic               gate_s2,
  output logic               gate_s1n,
  output logic               gate_s2n,
  output logic [1:0]         level
);

  localparam int RW = DW + MI_W + 1 - MI_FRAC;

  logic [LUT_AW-1:0]    rom_addr;
  logic [DW-2:0]        tri_a;
  logic [MI_W-1:0]      mi_act;
  disp_e                mode_act;
  logic signed [RW-1:0] ref_c;
  logic [DW-2:0]        tri_c;
  disp_e                mode_c;
  level_e               level_q;
  gates_t               gates_q;

  spwm3l_phase #(
    .PW(PW), .DW(DW), .LUT_AW(LUT_AW), .RATIO_W(RATIO_W), .MI_W(MI_W)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .freq_word (freq_word),
    .ratio     (ratio),
    .mi_in     (mod_index),
    .mode_in   (disp_e'(disp_mode)),
    .rom_addr  (rom_addr),
    .tri_a     (tri_a),
    .mi_act    (mi_act),
    .mode_act  (mode_act)
  );

  spwm3l_refpath #(
    .DW(DW), .LUT_AW(LUT_AW), .MI_W(MI_W), .MI_FRAC(MI_FRAC), .RW(RW)
  ) u_ref (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .tri_a    (tri_a),
    .mi_act   (mi_act),
    .mode_act (mode_act),
    .ref_c    (ref_c),
    .tri_c    (tri_c),
    .mode_c   (mode_c)
  );

  spwm3l_compare #(.DW(DW), .RW(RW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .ref_c   (ref_c),
    .tri_c   (tri_c),
    .mode_c  (mode_c),
    .level_q (level_q),
    .gates_q (gates_q)
  );

  assign gate_s1  = gates_q.s1;
  assign gate_s2  = gates_q.s2;
  assign gate_s1n = gates_q.s1n;
  assign gate_s2n = gates_q.s2n;
  assign level    = level_q;

endmodule

// File: tb/spwm3l_gen_tb.sv
`timescale 1ns/1ps
module spwm3l_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] freq_word = '0;
  logic [7:0]  ratio = '0;
  logic [9:0]  mod_index = '0;
  logic        disp_mode = 1'b0;
  logic gate_s1, gate_s2, gate_s1n, gate_s2n;
  logic [1:0] level;

  always #2.5 clk = ~clk;

  spwm3l_gen u_dut (
    .clk(clk), .rst(rst), .freq_word(freq_word), .ratio(ratio),
    .mod_index(mod_index), .disp_mode(disp_mode),
    .gate_s1(gate_s1), .gate_s2(gate_s2), .gate_s1n(gate_s1n),
    .gate_s2n(gate_s2n), .level(level)
  );

  int checks = 0;
  int errors = 0;
  int kcnt = 0;
  int step_model = 0;
  int map_err = 0, compl_err = 0, code_err = 0;
  bit done = 1'b0;
  int m_pulses, m_pos, m_neg, m_maxp, m_maxn, m_negmid;
  logic [1:0] prev_lvl = 2'b00;

  // columns: freq_word, ratio, mod_index, mode, min pulses, max pulses
  localparam int NT = 4;
  localparam int TBL [NT][6] = '{
    '{16,  9, 205, 0, 3, 6},
    '{16, 15, 205, 0, 6, 9},
    '{16,  9, 205, 1, 3, 6},
    '{32,  7, 128, 1, 2, 5}
  };

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [3:0] g, eg;
    @(posedge clk);
    if (!rst) kcnt++;
    #1;
    g = {gate_s1, gate_s2, gate_s1n, gate_s2n};
    case (level)
      2'b01: eg = 4'b1100;
      2'b00: eg = 4'b0110;
      2'b11: eg = 4'b0011;
      default: begin eg = 4'bxxxx; code_err++; end
    endcase
    if (level != 2'b10 && g != eg) map_err++;
    if (gate_s1 == gate_s1n || gate_s2 == gate_s2n) compl_err++;
  endtask

  task automatic do_reset(int fw, int ra, int mi, int md);
    freq_word = 16'(fw); ratio = 8'(ra); mod_index = 10'(mi); disp_mode = md[0];
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    kcnt = 0;
    step_model = (fw * ra) % 65536;
    prev_lvl = 2'b00;
  endtask

  task automatic measure(int n);
    int runp, runn, ph;
    m_pulses = 0; m_pos = 0; m_neg = 0; m_maxp = 0; m_maxn = 0; m_negmid = 0;
    runp = 0; runn = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (level == 2'b01) begin
        m_pos++; runp++;
        if (prev_lvl != 2'b01) m_pulses++;
        if (runp > m_maxp) m_maxp = runp;
      end else runp = 0;
      if (level == 2'b11) begin
        m_neg++; runn++;
        if (runn > m_maxn) m_maxn = runn;
        ph = ((kcnt - 3) * step_model) % 65536;
        if (ph >= 16384 && ph < 49152) m_negmid++;
      end else runn = 0;
      prev_lvl = level;
    end
  endtask

  initial begin
    #1250000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, cper, nz, diff, seen;

    // R1: reset state with non-zero settings applied
    freq_word = 16; ratio = 9; mod_index = 768; disp_mode = 1'b1;
    repeat (4) tick();
    chk("R1 level in reset", level == 2'b00, level, 0);
    chk("R1 gates in reset", {gate_s1, gate_s2, gate_s1n, gate_s2n} == 4'b0110,
        {gate_s1, gate_s2, gate_s1n, gate_s2n}, 4'b0110);
    rst = 1'b0; kcnt = 0;
    tick();
    chk("R1 level after reset", level == 2'b00, level, 0);

    // table walk: pulse count, balance, run length
    for (int t = 0; t < NT; t++) begin
      do_reset(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);
      per  = 65536 / TBL[t][0];
      cper = 65536 / (TBL[t][0] * TBL[t][1]);
      measure(per);
      measure(per);
      chk($sformatf("R5 pulses entry %0d", t),
          m_pulses >= TBL[t][4] && m_pulses <= TBL[t][5], m_pulses, TBL[t][4]);
      diff = (m_pos > m_neg) ? m_pos - m_neg : m_neg - m_pos;
      chk($sformatf("R6 balance entry %0d", t), diff <= m_pos / 16 + 8, m_neg, m_pos);
      chk($sformatf("R8 run below carrier period entry %0d", t), m_maxp < cper, m_maxp, cper);
    end

    // R4: zero index gives constant zero level
    do_reset(16, 9, 0, 0);
    measure(4096);
    chk("R4 zero index", m_pos + m_neg == 0, m_pos + m_neg, 0);

    // R7: negative pulse position in each disposition, switched at runtime
    do_reset(16, 9, 128, 0);
    measure(4096);
    measure(4096);
    chk("R7 in-phase neg mid-period", m_neg > 0 && m_negmid * 10 >= m_neg * 9, m_negmid, m_neg);
    disp_mode = 1'b1;
    measure(4096);
    measure(4096);
    chk("R7 opposed neg at boundary", m_neg > 0 && m_negmid * 10 <= m_neg, m_negmid, m_neg);

    // R9: index applied mid-period waits for the boundary
    do_reset(16, 9, 0, 0);
    nz = 0;
    while (kcnt < 100) tick();
    mod_index = 768;
    while (kcnt < 450) begin
      tick();
      if (level != 2'b00) nz++;
    end
    chk("R9 no output before boundary", nz == 0, nz, 0);
    seen = 0;
    for (int i = 0; i < 1500; i++) begin
      tick();
      if (level == 2'b01) seen = 1;
    end
    chk("R9 index taken after boundary", seen == 1, seen, 1);

    // R8: overmodulation holds extremes past a carrier period
    measure(8192);
    cper = 65536 / 144;
    chk("R8 overmod positive run", m_maxp > cper, m_maxp, cper);
    chk("R8 overmod negative run", m_maxn > cper, m_maxn, cper);

    // R2 and R3 over every sampled cycle
    chk("R2 legal level codes", code_err == 0, code_err, 0);
    chk("R2 gate pattern per level", map_err == 0, map_err, 0);
    chk("R3 complementary gates", compl_err == 0, compl_err, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule